// File: doc/BRIEF.md
# Serial Peripheral Frame Master

This block is the transmit/receive engine of a synchronous serial master. It takes words of 4 to 16 bits from a transmit queue and shifts them out most significant bit first on a serial data line. At the same time it shifts in the bits on the receive line and pushes each assembled word into a receive queue. It generates the serial clock and an active-low frame select. Clock polarity and clock phase are selectable, and the serial clock rate comes from a divider of the system clock.

A frame starts as soon as the block is enabled and the transmit queue offers a word. With phase 0, frame select is released after every word and then lowered again for the next word. With phase 1, a queue that stays non-empty produces one unbroken frame in which the words follow each other at the normal bit spacing. The polarity, phase, word length and divider inputs are expected to stay stable while `busy` is high.

Top module: `spi_frame_master`

## Requirements
- R1: Out of reset and while no frame is active, `sclk` equals `cpol`, `fss_n` is 1, `mosi` is 0, and `busy`, `rx_push` and `overrun` are 0.
- R2: A frame starts only when `enable` and `tx_valid` are both 1. `tx_pop` is asserted in that cycle, and `fss_n` is 0 from the next cycle on. With `enable` at 0, a queued word is never taken.
- R3: The word length is `wlen`+1 bits, and a `wlen` value below 3 is treated as 3. Transmit bits go out MSB first, and bits of `tx_data` above the word length are ignored. `rx_data` holds the received bits right-aligned, the first received bit being the most significant.
- R4: One half period lasts H = `half_div` system clocks, and a value of 0 counts as 1. The first clock edge comes 2·H cycles after `fss_n` falls, and it moves `sclk` away from its idle level. An N-bit word takes 2·N clock edges, spaced H cycles apart.
- R5: With `cpha`=0, the first bit appears on `mosi` H cycles after `fss_n` falls. `miso` is sampled on the leading edge of each bit, and `mosi` moves to the next bit on the trailing edge.
- R6: With `cpha`=1, `mosi` changes on the leading edge of each bit, and `miso` is sampled on the trailing edge.
- R7: `fss_n` rises 2·H cycles after the last bit of a frame is sampled. A single word therefore keeps `fss_n` low for (2N+2)·H cycles with `cpha`=0 and for (2N+3)·H cycles with `cpha`=1.
- R8: With `cpha`=0 and further words queued, `fss_n` goes high between consecutive words for exactly H+1 cycles. Each word gets its own frame.
- R9: With `cpha`=1 and further words queued, `fss_n` stays low. The next word is popped in the cycle of the previous word's last sample, so k words take (2N·k+3)·H low cycles.
- R10: After the last bit of a word is sampled, `rx_push` pulses for one cycle with the word on `rx_data`. If `rx_full` is 1 at that moment, the word is dropped and `overrun` is set. `overrun` stays set until reset.
- R11: `busy` is 1 whenever `fss_n` is 0. It is also 1 while the block is enabled and a word is queued, so it stays high through the gaps of a phase-0 run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows new frames to start |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| wlen | input | 4 | Word length minus one |
| half_div | input | 8 | System clocks per serial half period |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_data | input | 16 | Word at the head of the transmit queue |
| tx_pop | output | 1 | Takes the head word from the transmit queue |
| rx_full | input | 1 | Receive queue cannot accept a word |
| rx_push | output | 1 | Writes `rx_data` into the receive queue |
| rx_data | output | 16 | Last received word, right-aligned |
| overrun | output | 1 | Sticky: a received word was dropped |
| sclk | output | 1 | Serial clock |
| fss_n | output | 1 | Frame select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Frame active or word pending |

## Verification
A wrong bit counter or a misplaced phase decision shows up within the same word. The received word comes back shifted or inverted when `miso` is looped back from `mosi`, and the number of clock edges counted while `fss_n` is low is off. A wrong divider or tail count shows up as a wrong low duration of `fss_n` at the end of the very first frame. An error in the word-to-word handover shows up on the second word of a run: either an extra or missing frame-select pulse, or a wrong gap length. A lost or duplicated queue handshake shows up as a missing or extra `rx_push` before `busy` falls.

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int MAXW = 16,
  parameter int DIVW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     cpol,
  input  logic                     cpha,
  input  logic [$clog2(MAXW)-1:0]  wlen,
  input  logic [DIVW-1:0]          half_div,
  input  logic                     tx_valid,
  input  logic [MAXW-1:0]          tx_data,
  output logic                     tx_pop,
  input  logic                     rx_full,
  output logic                     rx_push,
  output logic [MAXW-1:0]          rx_data,
  output logic                     overrun,
  output logic                     sclk,
  output logic                     fss_n,
  output logic                     mosi,
  input  logic                     miso,
  output logic                     busy
);
  localparam int CW = $clog2(MAXW);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_RUN, S_TAIL, S_GAP} st_t;

  st_t             st;
  logic [DIVW-1:0] dc;
  logic            step, fin;
  logic [CW-1:0]   cnt;
  logic [MAXW-1:0] tsr, rsr;

  wire [CW-1:0]   wl    = (wlen < CW'(3)) ? CW'(3) : wlen;
  wire [DIVW-1:0] hd    = (half_div == '0) ? DIVW'(1) : half_div;
  wire            tick  = (st != S_IDLE) && (dc == hd - DIVW'(1));
  wire            lead  = (sclk == cpol);
  wire            last  = (cnt == wl);
  wire            more  = enable && tx_valid;
  wire            cap   = tick && ((st == S_SETUP && step && !cpha) ||
                                   (st == S_RUN && (lead ^ cpha)));
  wire            shf   = tick && ((st == S_SETUP && (step == cpha)) ||
                                   (st == S_RUN && (cpha ? lead : (!lead && !fin))));
  wire            start = (st == S_IDLE) && more;
  wire            chain = cap && last && cpha && (st == S_RUN) && more;
  wire [MAXW-1:0] rnext = {rsr[MAXW-2:0], miso};
  wire [MAXW-1:0] tload = tx_data << (MAXW - 1 - int'(wl));

  assign tx_pop = start || chain;
  assign busy   = !fss_n || more;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      dc      <= '0;
      step    <= 1'b0;
      fin     <= 1'b0;
      cnt     <= '0;
      tsr     <= '0;
      rsr     <= '0;
      rx_data <= '0;
      rx_push <= 1'b0;
      overrun <= 1'b0;
      sclk    <= cpol;
      fss_n   <= 1'b1;
      mosi    <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      dc      <= (st == S_IDLE || tick) ? '0 : dc + 1'b1;

      if (shf) begin
        mosi <= tsr[MAXW-1];
        tsr  <= tsr << 1;
      end

      if (cap) begin
        rsr <= rnext;
        if (last) begin
          cnt     <= '0;
          fin     <= 1'b1;
          rx_data <= rnext;
          if (rx_full) overrun <= 1'b1;
          else         rx_push <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      case (st)
        S_IDLE: begin
          sclk <= cpol;
          mosi <= 1'b0;
          if (start) begin
            st    <= S_SETUP;
            fss_n <= 1'b0;
            step  <= 1'b0;
            tsr   <= tload;
            rsr   <= '0;
            cnt   <= '0;
            fin   <= 1'b0;
          end
        end
        S_SETUP: if (tick) begin
          step <= 1'b1;
          if (step) begin
            sclk <= ~sclk;
            st   <= S_RUN;
          end
        end
        S_RUN: if (tick) begin
          sclk <= ~sclk;
          if (cpha && cap && last) begin
            if (more) begin
              tsr <= tload;
              rsr <= '0;
              cnt <= '0;
              fin <= 1'b0;
            end else begin
              st   <= S_TAIL;
              step <= 1'b1;
            end
          end else if (!cpha && !lead && fin) begin
            st   <= S_TAIL;
            step <= 1'b0;
          end
        end
        S_TAIL: if (tick) begin
          if (step) begin
            step <= 1'b0;
          end else begin
            fss_n <= 1'b1;
            mosi  <= 1'b0;
            st    <= S_GAP;
          end
        end
        S_GAP: if (tick) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cpol,
  input logic enable,
  input logic tx_valid,
  input logic tx_pop,
  input logic rx_full,
  input logic rx_push,
  input logic overrun,
  input logic sclk,
  input logic fss_n,
  input logic mosi,
  input logic busy
);
  a_r1_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (fss_n && $past(fss_n) && $stable(cpol)) |-> (sclk == cpol));

  a_r1_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
    fss_n |-> !mosi);

  a_r2_pop_guard: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (tx_valid && enable));

  a_r2_start_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && fss_n) |=> !fss_n);

  a_r10_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> $past(!rx_full));

  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  a_r7_push_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !fss_n);

  a_r11_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !fss_n |-> busy);
endmodule

bind spi_frame_master spi_frame_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpol(cpol), .enable(enable),
  .tx_valid(tx_valid), .tx_pop(tx_pop), .rx_full(rx_full),
  .rx_push(rx_push), .overrun(overrun), .sclk(sclk), .fss_n(fss_n),
  .mosi(mosi), .busy(busy)
);

// File: tb/tb_spi_frame_master.sv
`timescale 1ns/1ps
module tb_spi_frame_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, cpol = 1'b1, cpha = 1'b0, inv = 1'b0, rx_full = 1'b0;
  logic [3:0]  wlen = 4'd7;
  logic [7:0]  half_div = 8'd2;
  logic [15:0] fmem [16];
  logic [3:0]  rd, wr = 4'd0;
  logic        tx_valid, tx_pop, rx_push, overrun, sclk, fss_n, mosi, miso, busy;
  logic [15:0] tx_data, rx_data;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign tx_valid = (rd != wr);
  assign tx_data  = fmem[rd];
  assign miso     = mosi ^ inv;

  always @(posedge clk)
    if (!rst_n) rd <= 4'd0;
    else if (tx_pop) rd <= rd + 4'd1;

  spi_frame_master dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .cpha(cpha),
    .wlen(wlen), .half_div(half_div), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
    .overrun(overrun), .sclk(sclk), .fss_n(fss_n), .mosi(mosi), .miso(miso),
    .busy(busy)
  );

  int falls, edges, npush, low_cnt, last_low, hi_cnt, last_gap;
  logic first_dir, seen_edge, pf = 1'b1, ps = 1'b1;
  logic [15:0] rxq [8];

  always @(negedge clk) begin
    if (rst_n) begin
      if (!fss_n && pf) begin falls++; low_cnt = 0; seen_edge = 0; last_gap = hi_cnt; end
      if (!fss_n) begin
        low_cnt++;
        if (sclk != ps) begin
          edges++;
          if (!seen_edge) begin seen_edge = 1; first_dir = sclk; end
        end
      end
      if (fss_n && !pf) begin last_low = low_cnt; hi_cnt = 0; end
      if (fss_n) hi_cnt++;
      if (rx_push) begin rxq[npush[2:0]] = rx_data; npush++; end
    end
    pf = fss_n;
    ps = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    falls = 0; edges = 0; npush = 0; low_cnt = 0; last_low = 0;
    hi_cnt = 0; last_gap = 0; seen_edge = 0;
  endtask

  task automatic push(input logic [15:0] w);
    fmem[wr] = w;
    wr = wr + 4'd1;
  endtask

  task automatic wait_done(input int nf, output int blow);
    blow = 0;
    do begin
      @(negedge clk); #1;
      if (!busy && (falls < nf || !fss_n)) blow++;
    end while (!(falls >= nf && fss_n && !busy));
    repeat (12) @(negedge clk);
    #1;
  endtask

  // cpol cpha inv | wlen | half_div | word
  localparam logic [30:0] VEC [0:7] = '{
    {3'b100, 4'd7,  8'd2, 16'h00A5},
    {3'b110, 4'd15, 8'd1, 16'hC35A},
    {3'b001, 4'd3,  8'd3, 16'h0009},
    {3'b010, 4'd11, 8'd2, 16'h0ABC},
    {3'b101, 4'd15, 8'd0, 16'h8001},
    {3'b111, 4'd4,  8'd4, 16'h0016},
    {3'b000, 4'd1,  8'd1, 16'h0FFA},
    {3'b100, 4'd9,  8'd5, 16'h02AB}
  };

  initial begin
    int blow, n, h, expw, el;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk); #1;
    // R1 reset state
    chk(sclk == cpol, "R1 sclk idle", sclk, cpol);
    chk(fss_n == 1'b1, "R1 fss idle", fss_n, 1);
    chk(mosi == 1'b0, "R1 mosi idle", mosi, 0);
    chk({busy, rx_push, overrun} == 3'b000, "R1 flags clear", {busy, rx_push, overrun}, 0);

    enable = 1'b1;
    for (int i = 0; i < 8; i++) begin
      {cpol, cpha, inv} = VEC[i][30:28];
      wlen = VEC[i][27:24];
      half_div = VEC[i][23:16];
      repeat (3) @(negedge clk); #1;
      clr();
      n = (wlen < 3) ? 4 : int'(wlen) + 1;
      h = (half_div == 0) ? 1 : int'(half_div);
      expw = int'(inv ? ~VEC[i][15:0] : VEC[i][15:0]) & ((1 << n) - 1);
      el = cpha ? (2 * n + 3) * h : (2 * n + 2) * h;
      push(VEC[i][15:0]);
      wait_done(1, blow);
      chk(npush == 1, "R10 one push per word", npush, 1);
      chk(int'(rxq[0]) == expw, cpha ? "R6 R3 rx word" : "R5 R3 rx word", int'(rxq[0]), expw);
      chk(last_low == el, "R7 R4 frame length", last_low, el);
      chk(edges == 2 * n, "R4 edge count", edges, 2 * n);
      chk(first_dir == ~cpol, "R4 first edge leaves idle", first_dir, ~cpol);
      chk(sclk == cpol && !mosi, "R1 idle after frame", {sclk, mosi}, {cpol, 1'b0});
    end

    // R2 disabled: queued word must stay untouched
    {cpol, cpha, inv} = 3'b100; wlen = 4'd7; half_div = 8'd2;
    enable = 1'b0;
    repeat (3) @(negedge clk); #1;
    clr();
    push(16'h003C);
    repeat (40) @(negedge clk); #1;
    chk(falls == 0 && fss_n, "R2 no start while disabled", falls, 0);
    chk(busy == 1'b0, "R11 idle busy while disabled", busy, 0);
    chk(tx_valid == 1'b1, "R2 word kept while disabled", tx_valid, 1);
    enable = 1'b1;
    wait_done(1, blow);
    chk(falls == 1 && npush == 1, "R2 start after enable", npush, 1);
    chk(rxq[0] == 16'h003C, "R2 word after enable", rxq[0], 16'h003C);

    // R8 phase 0 back-to-back
    clr();
    push(16'h0011); push(16'h0022); push(16'h0033);
    wait_done(3, blow);
    chk(falls == 3, "R8 frame per word", falls, 3);
    chk(last_gap == 3, "R8 select gap", last_gap, 3);
    chk(last_low == 36, "R8 frame length", last_low, 36);
    chk(npush == 3 && rxq[1] == 16'h0022 && rxq[2] == 16'h0033, "R8 run data", rxq[2], 16'h0033);
    chk(blow == 0, "R11 busy through gaps", blow, 0);

    // R9 phase 1 back-to-back
    cpha = 1'b1;
    repeat (3) @(negedge clk); #1;
    clr();
    push(16'h0081); push(16'h007E); push(16'h00F0);
    wait_done(1, blow);
    chk(falls == 1, "R9 single select", falls, 1);
    chk(edges == 48, "R9 edge count", edges, 48);
    chk(last_low == 102, "R9 run length", last_low, 102);
    chk(npush == 3 && rxq[0] == 16'h0081 && rxq[1] == 16'h007E && rxq[2] == 16'h00F0,
        "R9 run data", rxq[1], 16'h007E);
    chk(blow == 0, "R11 busy over run", blow, 0);

    // R10 overrun
    cpha = 1'b0; rx_full = 1'b1;
    repeat (3) @(negedge clk); #1;
    clr();
    push(16'h0055);
    wait_done(1, blow);
    chk(npush == 0, "R10 dropped when full", npush, 0);
    chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
    rx_full = 1'b0;
    clr();
    push(16'h00AA);
    wait_done(1, blow);
    chk(npush == 1 && rxq[0] == 16'h00AA, "R10 push after room", npush, 1);
    chk(overrun == 1'b1, "R10 overrun sticky", overrun, 1);
    chk(busy == 1'b0, "R11 busy clear at end", busy, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule